// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block watches the six live calendar counters of a real-time clock (seconds, minutes, hours, weekday, day of month, month) and compares them with six software-programmed alarm bytes. Each alarm byte carries its own compare enable. Any subset of fields can take part in the match, so the same hardware can raise a daily, a weekly or a one-off alarm.

The comparison runs only on the cycle in which the once-per-second update strobe is high. When at least one field is enabled and every enabled field equals its counter, a sticky alarm flag is set. Software reads and clears the flag through a small byte register port. That port also holds the alarm interrupt enable. The interrupt line is high while both the flag and the enable are set. The year is not compared.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, all six alarm bytes read 0x00, the control byte reads 0x00 and `irq_o` is low.
- R2: Register map by `reg_addr`: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month and 5 month alarm bytes, with write data stored whole and read back unchanged; 6 is the control byte; other addresses read 0x00. Reads are combinational.
- R3: In an alarm byte, bit 7 is the field's compare enable and bits 6:0 hold the BCD value. An enabled field matches when its counter byte equals {0, bits 6:0}. When `tick_i` is high and every enabled field matches, the alarm flag is set on that clock edge and is visible from the next cycle.
- R4: A field whose bit 7 is 0 is left out of the match. Any subset of the six fields can be enabled.
- R5: If no field is enabled, a strobe never sets the flag.
- R6: Without `tick_i`, matching counters never set the flag.
- R7: The flag stays set until a control write with bit 0 equal to 0. A control write with bit 0 equal to 1 leaves the flag as it is. A setting match wins over a clearing write in the same cycle.
- R8: Control byte layout: bit 0 is the alarm flag, bit 3 is the alarm interrupt enable (written directly), and the other bits read 0. `irq_o` is high exactly when both bit 0 and bit 3 are set.
- R9: The month field matches as BCD 0x01 to 0x12, with the tens digit included, for example 0x10 and 0x12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle seconds update strobe |
| sec_i | input | 8 | BCD seconds counter |
| min_i | input | 8 | BCD minutes counter |
| hour_i | input | 8 | BCD hours counter |
| wday_i | input | 8 | BCD weekday counter |
| mday_i | input | 8 | BCD day-of-month counter |
| mon_i | input | 8 | BCD month counter (1 to 12) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The assertions assume that `tick_i` is a single-cycle pulse. They also assume that the counter inputs are stable BCD bytes with bit 7 clear whenever the strobe is high. The bench drives every input on the falling clock edge. It changes counters only while the strobe is low. It uses only valid BCD values for the alarm and counter bytes. The sweep covers every one of the 64 enable subsets. Each subset is tried with all fields equal and with each single field mismatching in turn.

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [7:0]        sec_i,
  input  logic [7:0]        min_i,
  input  logic [7:0]        hour_i,
  input  logic [7:0]        wday_i,
  input  logic [7:0]        mday_i,
  input  logic [7:0]        mon_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_o
);
  localparam int FIELDS = 6;
  localparam int CTRL_ADDR = FIELDS;
  localparam int FLAG_BIT = 0;
  localparam int AIE_BIT = 3;

  logic [7:0] alarm_q [FIELDS];
  logic [7:0] cnt [FIELDS];
  logic [FIELDS-1:0] field_ok;
  logic [FIELDS-1:0] field_en;
  logic flag_q, aie_q, hit, ctrl_wr;

  assign cnt[0] = sec_i;
  assign cnt[1] = min_i;
  assign cnt[2] = hour_i;
  assign cnt[3] = wday_i;
  assign cnt[4] = mday_i;
  assign cnt[5] = mon_i;

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    assign field_en[i] = alarm_q[i][7];
    assign field_ok[i] = !field_en[i] || (cnt[i] == {1'b0, alarm_q[i][6:0]});

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        alarm_q[i] <= 8'h00;
      else if (reg_we && reg_addr == ADDR_W'(i))
        alarm_q[i] <= reg_wdata;
    end

    assert_alarm_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == ADDR_W'(i)) |=> $stable(alarm_q[i]));
  end

  assign hit = tick_i && (|field_en) && (&field_ok);
  assign ctrl_wr = reg_we && reg_addr == ADDR_W'(CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      aie_q  <= 1'b0;
    end else begin
      if (hit)
        flag_q <= 1'b1;
      else if (ctrl_wr && !reg_wdata[FLAG_BIT])
        flag_q <= 1'b0;
      if (ctrl_wr)
        aie_q <= reg_wdata[AIE_BIT];
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr < ADDR_W'(FIELDS))
      reg_rdata = alarm_q[reg_addr];
    else if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
      reg_rdata[FLAG_BIT] = flag_q;
      reg_rdata[AIE_BIT]  = aie_q;
    end
  end

  assign irq_o = flag_q & aie_q;

  assert_match_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);

  assert_no_field_no_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (field_en == '0 && !flag_q) |=> !flag_q);

  assert_rise_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick_i));

  assert_fall_needs_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(ctrl_wr && !reg_wdata[FLAG_BIT]));

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (reg_addr != ADDR_W'(CTRL_ADDR)) || (reg_rdata[FLAG_BIT] && reg_rdata[AIE_BIT]));
endmodule

// File: tb/alarm_match_unit_tb_top.sv
module alarm_match_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0, reg_we = 1'b0;
  logic [7:0] sec_i = 0, min_i = 0, hour_i = 0, wday_i = 0, mday_i = 0, mon_i = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] aval [6];
  logic [7:0] wrong [6];

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_match_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i),
    .wday_i(wday_i), .mday_i(mday_i), .mon_i(mon_i),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic set_cnt(logic [7:0] c [6]);
    sec_i = c[0]; min_i = c[1]; hour_i = c[2];
    wday_i = c[3]; mday_i = c[4]; mon_i = c[5];
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] d;
    logic [7:0] c [6];
    aval = '{8'h45, 8'h37, 8'h23, 8'h06, 8'h31, 8'h12};
    wrong = '{8'h44, 8'h36, 8'h22, 8'h05, 8'h30, 8'h11};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reset read", d, 8'h00);
    end
    check("R1 reset irq", {7'b0, irq_o}, 8'h00);

    for (int a = 0; a < 6; a++) wr(3'(a), 8'h80 | 8'(a * 17));
    wr(3'd7, 8'hff);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R2 readback", d, 8'h80 | 8'(a * 17));
    end
    rd(3'd7, d);
    check("R2 unused address", d, 8'h00);

    for (int m = 0; m < 64; m++) begin
      for (int k = 0; k <= 6; k++) begin
        logic exp_hit;
        wr(3'd6, 8'h00);
        for (int f = 0; f < 6; f++)
          wr(3'(f), m[f] ? (8'h80 | aval[f]) : aval[f]);
        for (int f = 0; f < 6; f++) c[f] = (f == k) ? wrong[f] : aval[f];
        set_cnt(c);
        pulse();
        exp_hit = (m != 0) && (k == 6 || !m[k]);
        rd(3'd6, d);
        if (m == 0) check("R5 no field enabled", d, 8'h00);
        else if (k == 6) check("R3 full match", d, 8'h01);
        else check("R4 masked sweep", d, {7'b0, exp_hit});
      end
    end

    wr(3'd6, 8'h00);
    for (int f = 0; f < 6; f++) wr(3'(f), 8'h80 | aval[f]);
    set_cnt(aval);
    repeat (4) @(negedge clk);
    rd(3'd6, d);
    check("R6 no tick", d, 8'h00);

    pulse();
    c = aval; c[0] = 8'h46; set_cnt(c);
    repeat (3) @(negedge clk);
    rd(3'd6, d);
    check("R7 sticky after counters move", d, 8'h01);
    wr(3'd6, 8'h01);
    rd(3'd6, d);
    check("R7 write 1 keeps flag", d, 8'h01);
    check("R8 irq disabled", {7'b0, irq_o}, 8'h00);
    wr(3'd6, 8'h09);
    rd(3'd6, d);
    check("R8 control layout", d, 8'h09);
    check("R8 irq asserted", {7'b0, irq_o}, 8'h01);
    wr(3'd6, 8'h08);
    rd(3'd6, d);
    check("R7 write 0 clears", d, 8'h08);
    check("R8 irq low without flag", {7'b0, irq_o}, 8'h00);

    set_cnt(aval);
    @(negedge clk);
    tick_i = 1'b1; reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h00;
    @(negedge clk);
    tick_i = 1'b0; reg_we = 1'b0;
    rd(3'd6, d);
    check("R7 set wins over clear", d, 8'h01);

    wr(3'd6, 8'h00);
    for (int f = 0; f < 5; f++) wr(3'(f), 8'h00);
    wr(3'd5, 8'h90);
    c = aval; c[5] = 8'h10; set_cnt(c);
    pulse();
    rd(3'd6, d);
    check("R9 month 0x10 match", d, 8'h01);
    wr(3'd6, 8'h00);
    c[5] = 8'h00; set_cnt(c);
    pulse();
    rd(3'd6, d);
    check("R9 month tens digit compared", d, 8'h00);
    wr(3'd5, 8'h92);
    c[5] = 8'h12; set_cnt(c);
    pulse();
    rd(3'd6, d);
    check("R9 month 0x12 match", d, 8'h01);

    summary();
  end
endmodule